// File: doc/BRIEF.md
# LCD Blink and Bank-Swap Timing Controller

This block derives the blink rhythm of a segment LCD driver from the display clock. A single down-scaling counter divides the clock by one of three selectable factors and produces a blink phase. While the phase is in its second half, the controller either blanks every segment or, where the drive mode permits, shows the alternate RAM bank in place of the primary one. The serial interface, command decoding, display RAM and waveform generation sit outside this block and use its outputs.

Software can blink the display at a rate of its own by toggling the display-enable input, because that input blanks the display regardless of the blink phase. A one-cycle tick marks every phase change, so neighbouring logic can rewrite display RAM at fixed intervals. This is the way to make segment groups blink selectively in the 1:3 and 1:4 drive modes, which have no alternate bank.

Top module: `lcd_blink_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it is released with blink rate 0 and display enabled, `dispBlank`, `bankSel` and `blinkTick` are all 0.
- R2: With `blinkRate` = 0 the blink is off: `blinkTick` stays 0, `bankSel` stays 0 and `dispBlank` equals the inverse of `dispEnable`.
- R3: Rate 1 gives a blink period of 768 clocks. The phase is visible for 384 clocks and then blanked (or swapped) for 384 clocks.
- R4: Rate 2 gives a blink period of 1536 clocks, with 768 clocks in each half.
- R5: Rate 3 gives a blink period of 3072 clocks, with 1536 clocks in each half.
- R6: `blinkTick` is high for exactly one clock on each phase change. It rises on the same edge that starts the new phase.
- R7: When `bankSwapEn` is 1 and `driveMode` is 00 (static) or 01 (1:2), the second half of each period sets `bankSel` to 1 (alternate bank), and `dispBlank` stays 0 while the display is enabled.
- R8: When `driveMode` is 10 (1:3) or 11 (1:4), `bankSel` stays 0. A swap request then falls back to blanking the whole display in the second half of each period.
- R9: When `dispEnable` is 0, `dispBlank` is 1 whatever the blink phase. The phase, the tick and `bankSel` keep running undisturbed.
- R10: Any change of `blinkRate` restarts the count on the next edge. The display then shows the visible, primary-bank phase for a full half period at the new rate, and no tick occurs on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rstN | input | 1 | Active-low synchronous reset |
| blinkRate | input | 2 | 0 off, 1 /768, 2 /1536, 3 /3072 |
| bankSwapEn | input | 1 | Swap the bank instead of blanking |
| driveMode | input | 2 | 00 static, 01 1:2, 10 1:3, 11 1:4 |
| dispEnable | input | 1 | Display on; 0 forces blanking |
| dispBlank | output | 1 | 1 blanks all segments |
| bankSel | output | 1 | 0 primary bank, 1 alternate bank |
| blinkTick | output | 1 | One-clock pulse at each phase change |

## Verification
A rate change and a phase wrap can fall on the same clock edge. The bench provokes this by starting rate 1 and then switching to rate 3 on the negative edge just before the 384th count would wrap. The restart must win on that edge: the phase stays visible, no tick is emitted, and the new rate's full half period follows. A cleared display enable during a swap window is also judged: blanking must be forced while `bankSel` keeps toggling.

// File: rtl/blink_pkg.sv
package blink_pkg;

  typedef enum logic [1:0] {
    DRV_STATIC  = 2'b00,
    DRV_DUPLEX  = 2'b01,
    DRV_TRIPLEX = 2'b10,
    DRV_QUAD    = 2'b11
  } driveMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       clear;    // restart count and phase
    logic       run;      // blinking active
    logic [1:0] rateSel;  // selected divider
  } blinkStrobe_t;

endpackage

// File: rtl/blink_datapath.sv
module blink_datapath
  import blink_pkg::*;
#(
  parameter int BASE_HALF = 384,
  parameter int CNT_W     = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  blinkStrobe_t strb,
  output logic         phase,
  output logic         tick
);

  localparam int NUM_RATES = 3;

  logic [CNT_W-1:0] limitTbl [NUM_RATES];
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;
  logic             atLimit;

  // Half-period limits double with each rate step
  for (genvar r = 0; r < NUM_RATES; r++) begin : g_limit
    assign limitTbl[r] = CNT_W'((BASE_HALF << r) - 1);
  end

  always_comb begin
    case (strb.rateSel)
      2'd1:    limit = limitTbl[0];
      2'd2:    limit = limitTbl[1];
      2'd3:    limit = limitTbl[2];
      default: limit = '0;
    endcase
  end

  assign atLimit = (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= 1'b0;
      tick  <= 1'b0;
    end else if (strb.clear || !strb.run) begin
      cnt   <= '0;
      phase <= 1'b0;
      tick  <= 1'b0;
    end else if (atLimit) begin
      cnt   <= '0;
      phase <= ~phase;
      tick  <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/blink_ctrl.sv
module blink_ctrl
  import blink_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   blinkRate,
  input  logic         bankSwapEn,
  input  logic [1:0]   driveMode,
  input  logic         dispEnable,
  input  logic         phase,
  output blinkStrobe_t strb,
  output logic         dispBlank,
  output logic         bankSel
);

  logic [1:0] rateQ;
  logic       blinkOn;
  logic       swapOk;
  driveMode_e drv;

  always_ff @(posedge clk) begin
    if (!rstN) rateQ <= 2'd0;
    else       rateQ <= blinkRate;
  end

  assign drv     = driveMode_e'(driveMode);
  assign blinkOn = (blinkRate != 2'd0);
  assign swapOk  = bankSwapEn && (drv == DRV_STATIC || drv == DRV_DUPLEX);

  always_comb begin
    strb.clear   = (blinkRate != rateQ);
    strb.run     = blinkOn;
    strb.rateSel = blinkRate;
  end

  assign dispBlank = !dispEnable || (blinkOn && phase && !swapOk);
  assign bankSel   = blinkOn && phase && swapOk;

endmodule

// File: rtl/lcd_blink_ctrl.sv
module lcd_blink_ctrl
  import blink_pkg::*;
#(
  parameter int BASE_HALF = 384
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] blinkRate,
  input  logic       bankSwapEn,
  input  logic [1:0] driveMode,
  input  logic       dispEnable,
  output logic       dispBlank,
  output logic       bankSel,
  output logic       blinkTick
);

  localparam int CNT_W = $clog2(BASE_HALF * 4);

  blinkStrobe_t strb;
  logic         phase;

  blink_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .blinkRate  (blinkRate),
    .bankSwapEn (bankSwapEn),
    .driveMode  (driveMode),
    .dispEnable (dispEnable),
    .phase      (phase),
    .strb       (strb),
    .dispBlank  (dispBlank),
    .bankSel    (bankSel)
  );

  blink_datapath #(
    .BASE_HALF (BASE_HALF),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .phase (phase),
    .tick  (blinkTick)
  );

endmodule

// File: rtl/lcd_blink_checker.sv
module lcd_blink_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] blinkRate,
  input logic       bankSwapEn,
  input logic [1:0] driveMode,
  input logic       dispEnable,
  input logic       dispBlank,
  input logic       bankSel,
  input logic       blinkTick
);

  // R6: a tick never lasts two cycles
  p_tick_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    blinkTick |=> !blinkTick);

  // R2: no tick once the rate has been zero for a full cycle
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (blinkRate == 2'd0 && $past(blinkRate) == 2'd0) |-> (!blinkTick && !bankSel));

  // R7: swapping in static or 1:2 never blanks an enabled display
  p_swap_visible_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bankSwapEn && !driveMode[1] && dispEnable) |-> !dispBlank);

  // R8: 1:3 and 1:4 stay on the primary bank
  p_primary_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    driveMode[1] |-> !bankSel);

  // R9: disabled display is always blank
  p_disable_blank_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dispEnable |-> dispBlank);

  // R10: a rate change never produces a tick on the restart edge
  p_restart_no_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    (blinkRate != $past(blinkRate)) |=> !blinkTick);

endmodule

bind lcd_blink_ctrl lcd_blink_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .blinkRate  (blinkRate),
  .bankSwapEn (bankSwapEn),
  .driveMode  (driveMode),
  .dispEnable (dispEnable),
  .dispBlank  (dispBlank),
  .bankSel    (bankSel),
  .blinkTick  (blinkTick)
);

// File: tb/sim_lcd_blink_ctrl.sv
`timescale 1ns/1ps
module sim_lcd_blink_ctrl;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] blinkRate;
  logic       bankSwapEn;
  logic [1:0] driveMode;
  logic       dispEnable;
  logic       dispBlank;
  logic       bankSel;
  logic       blinkTick;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  lcd_blink_ctrl u0 (
    .clk        (clk),
    .rstN       (rstN),
    .blinkRate  (blinkRate),
    .bankSwapEn (bankSwapEn),
    .driveMode  (driveMode),
    .dispEnable (dispEnable),
    .dispBlank  (dispBlank),
    .bankSel    (bankSel),
    .blinkTick  (blinkTick)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Applies settings at a negedge and compares every following negedge
  // against the model; one check per window.
  task automatic runWindow(input logic [1:0] rate, input logic swap,
                           input logic [1:0] drv, input logic en,
                           input int samples, input bit preClear,
                           input string tag);
    int half;
    int errs;
    int firstAct;
    int firstExp;
    bit on;
    bit swapOk;
    if (preClear) begin
      blinkRate = 2'd0;
      repeat (2) @(negedge clk);
    end
    blinkRate  = rate;
    bankSwapEn = swap;
    driveMode  = drv;
    dispEnable = en;
    half   = (rate == 2'd0) ? 1 : (384 << (rate - 1));
    on     = (rate != 2'd0);
    swapOk = swap && !drv[1];
    errs = 0; firstAct = 0; firstExp = 0;
    for (int k = 1; k <= samples; k++) begin
      int  edges;
      bit  ph;
      bit  expTick;
      bit  expBlank;
      bit  expBank;
      @(negedge clk);
      edges    = k - 1;
      ph       = on && (((edges / half) % 2) == 1);
      expTick  = on && (edges > 0) && ((edges % half) == 0);
      expBlank = !en || (ph && !swapOk);
      expBank  = ph && swapOk;
      if ({dispBlank, bankSel, blinkTick} != {expBlank, expBank, expTick}) begin
        if (errs == 0) begin
          firstAct = {29'd0, dispBlank, bankSel, blinkTick};
          firstExp = {29'd0, expBlank, expBank, expTick};
        end
        errs++;
      end
    end
    check(errs == 0, tag, "window {blank,bank,tick}", firstAct, firstExp);
  endtask

  task automatic t_reset();
    rstN = 1'b0; blinkRate = 2'd0; bankSwapEn = 1'b0;
    driveMode = 2'b00; dispEnable = 1'b1;
    repeat (3) @(negedge clk);
    check({dispBlank, bankSel, blinkTick} == 3'b000, "R1", "in reset",
          {dispBlank, bankSel, blinkTick}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({dispBlank, bankSel, blinkTick} == 3'b000, "R1", "after reset",
          {dispBlank, bankSel, blinkTick}, 0);
  endtask

  task automatic t_off();
    runWindow(2'd0, 1'b0, 2'b00, 1'b1, 2000, 1'b1, "R2 enabled");
    runWindow(2'd0, 1'b1, 2'b01, 1'b0, 50,   1'b1, "R2 disabled");
  endtask

  task automatic t_rates();
    runWindow(2'd1, 1'b0, 2'b10, 1'b1, 2*768  + 2, 1'b1, "R3 R6 rate1");
    runWindow(2'd2, 1'b0, 2'b11, 1'b1, 2*1536 + 2, 1'b1, "R4 R6 rate2");
    runWindow(2'd3, 1'b0, 2'b00, 1'b1, 2*3072 + 2, 1'b1, "R5 R6 rate3");
  endtask

  task automatic t_swap();
    runWindow(2'd1, 1'b1, 2'b00, 1'b1, 2*768 + 2, 1'b1, "R7 static");
    runWindow(2'd2, 1'b1, 2'b01, 1'b1, 2*1536 + 2, 1'b1, "R7 duplex");
  endtask

  task automatic t_fallback();
    runWindow(2'd1, 1'b1, 2'b10, 1'b1, 2*768 + 2, 1'b1, "R8 triplex");
    runWindow(2'd1, 1'b1, 2'b11, 1'b1, 2*768 + 2, 1'b1, "R8 quad");
  endtask

  task automatic t_disable();
    runWindow(2'd1, 1'b0, 2'b00, 1'b0, 2*768 + 2, 1'b1, "R9 blank mode");
    runWindow(2'd1, 1'b1, 2'b01, 1'b0, 2*768 + 2, 1'b1, "R9 swap mode");
  endtask

  task automatic t_restart();
    // Mid-second-half, switch rate without passing through zero
    runWindow(2'd1, 1'b0, 2'b00, 1'b1, 500, 1'b1, "R3 lead-in");
    runWindow(2'd2, 1'b0, 2'b00, 1'b1, 2*768 + 2, 1'b0, "R10 restart");
  endtask

  task automatic t_collide();
    // Rate change lands on the edge where rate 1 would wrap
    runWindow(2'd1, 1'b1, 2'b00, 1'b1, 384, 1'b1, "R10 pre-wrap");
    runWindow(2'd3, 1'b1, 2'b00, 1'b1, 2*1536 + 2, 1'b0, "R10 R6 collide");
  endtask

  initial begin
    #(200000 * 10);
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    @(negedge clk);
    t_reset();
    t_off();
    t_rates();
    t_swap();
    t_fallback();
    t_disable();
    t_restart();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule